// File: doc/BRIEF.md
# SerDes Control-Register Command Port

This block is a small command port that sits inside the register space of a physical-layer block. It gives software access to a second, slower bus of SerDes control registers that software cannot reach directly. Software sees three ordinary 16-bit registers: a command/status word, a target-address word and a data word. Each one is reached with a single-cycle host write or a combinational host read.

To move data across, software first waits until the command/status word shows idle. It then loads the target address, and for a write it also loads the data word. Finally it writes the command/status word with the start bit set and the direction bit chosen. The port takes a copy of the command and keeps the busy flag high for a fixed, parameterised number of cycles while the internal access runs. For a read, it places the fetched word into the data register in the same cycle that busy drops. In this project the internal bus is modelled as a small word-addressed memory that lives inside the block.

Top module: `serdes_cr_port`

## Requirements
- R1: After reset, the command/status word, the address register and the data register all read as 0x0000.
- R2: The command/status word is at BASE_ADDR (default 0x80a0), the address register at BASE_ADDR+1 and the data register at BASE_ADDR+2. Any other host address reads 0x0000, and a write to it changes none of the three registers.
- R3: A host write to the command/status word with bit 0 = 1 while idle starts a command. From the next cycle, bit 0 of the command/status word reads 1 for exactly LATENCY cycles (LATENCY is at least 1), then reads 0.
- R4: Bit 1 of the write that starts a command selects the direction: 1 means an internal write and 0 means an internal read. Bit 1 of the command/status word reads back the direction of the last accepted command. Bits 15:2 read 0.
- R5: An internal write stores the data register into internal word (address mod MEM_WORDS). Two addresses that are equal modulo MEM_WORDS reach the same word.
- R6: For an internal read, once busy has cleared the data register holds the internal word at the address that was captured when the command started.
- R7: A write to the command/status word with bit 0 = 0 starts nothing and does not change the readback direction bit.
- R8: A start written while busy is ignored. The running command keeps its original end time and direction, and no second access takes place.
- R9: While busy, host writes to the address and data registers are ignored. The address and data used by the command are the values held when the start was accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 16 | Host register address for both reads and writes |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Combinational readback of the register selected by host_addr |

## Verification
The hardest situations to reach from the ports are the ones where software breaks the polling rule: a second start, or a new address or data value, arriving while a command is still running. The bench reaches these by issuing the extra host writes on the cycle directly after the accepting write, before it begins polling. It then counts the remaining busy cycles and reads back the direction, address and data. Wrap-around in the internal address space is reached by writing two addresses that differ only above the index bits, and then reading back the first one.

// File: rtl/serdes_cr_pkg.sv
package serdes_cr_pkg;

   localparam int unsigned WORD_W = 16;
   localparam int unsigned START_BIT = 0;
   localparam int unsigned DIR_BIT = 1;

   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CMD  = 2'd1,
      SEL_ADR  = 2'd2,
      SEL_DAT  = 2'd3
   } sel_e;

   typedef struct packed {
      logic  is_write;
      word_t addr;
      word_t data;
   } cmd_t;

endpackage

// File: rtl/serdes_cr_decode.sv
module serdes_cr_decode
   import serdes_cr_pkg::*;
#(
   parameter logic [15:0] BASE_ADDR = 16'h80a0
)(
   input  logic [15:0] host_addr,
   output sel_e        sel
);
   localparam logic [15:0] CMD_ADDR = BASE_ADDR;
   localparam logic [15:0] ADR_ADDR = BASE_ADDR + 16'd1;
   localparam logic [15:0] DAT_ADDR = BASE_ADDR + 16'd2;

   always_comb begin
      unique case (host_addr)
         CMD_ADDR: sel = SEL_CMD;
         ADR_ADDR: sel = SEL_ADR;
         DAT_ADDR: sel = SEL_DAT;
         default:  sel = SEL_NONE;
      endcase
   end
endmodule

// File: rtl/serdes_cr_regs.sv
module serdes_cr_regs
   import serdes_cr_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  host_wr,
   input  sel_e  sel,
   input  word_t host_wdata,
   input  logic  busy,
   input  logic  rd_done,
   input  word_t rd_word,
   output logic  accept,
   output logic  dir_q,
   output word_t addr_q,
   output word_t data_q,
   output word_t host_rdata
);
   logic wr_cmd, wr_adr, wr_dat;

   assign wr_cmd = host_wr && (sel == SEL_CMD);
   assign wr_adr = host_wr && (sel == SEL_ADR) && !busy;
   assign wr_dat = host_wr && (sel == SEL_DAT) && !busy;
   assign accept = wr_cmd && host_wdata[START_BIT] && !busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q  <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         if (accept) dir_q <= host_wdata[DIR_BIT];
         if (wr_adr) addr_q <= host_wdata;
         if (rd_done)     data_q <= rd_word;
         else if (wr_dat) data_q <= host_wdata;
      end
   end

   always_comb begin
      host_rdata = '0;
      unique case (sel)
         SEL_CMD: begin
            host_rdata[START_BIT] = busy;
            host_rdata[DIR_BIT]   = dir_q;
         end
         SEL_ADR: host_rdata = addr_q;
         SEL_DAT: host_rdata = data_q;
         default: host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/serdes_cr_engine.sv
module serdes_cr_engine
   import serdes_cr_pkg::*;
#(
   parameter int unsigned LATENCY = 4,
   parameter int unsigned IDX_W   = 6
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  cmd_t             cmd_in,
   output logic             busy,
   output logic             done,
   output logic             rd_done,
   output logic             mem_we,
   output logic [IDX_W-1:0] mem_idx,
   output word_t            mem_wdata
);
   localparam int unsigned CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;

   cmd_t cmd_q;
   logic busy_q;
   logic last;
   logic unused_hi;

   generate
      if (LATENCY == 1) begin : g_single
         assign last = 1'b1;
      end else begin : g_count
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                          cnt_q <= '0;
            else if (accept)                     cnt_q <= CW'(LATENCY - 1);
            else if (busy_q && (cnt_q != '0))    cnt_q <= cnt_q - 1'b1;
         end
         assign last = (cnt_q == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cmd_q  <= '0;
      end else begin
         if (accept) begin
            busy_q <= 1'b1;
            cmd_q  <= cmd_in;
         end else if (done) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign busy      = busy_q;
   assign done      = busy_q && last;
   assign rd_done   = done && !cmd_q.is_write;
   assign mem_we    = done && cmd_q.is_write;
   assign mem_idx   = cmd_q.addr[IDX_W-1:0];
   assign mem_wdata = cmd_q.data;
   assign unused_hi = ^cmd_q.addr[WORD_W-1:IDX_W];
endmodule

// File: rtl/serdes_cr_mem.sv
module serdes_cr_mem
   import serdes_cr_pkg::*;
#(
   parameter int unsigned MEM_WORDS = 64,
   parameter int unsigned IDX_W     = 6
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx,
   input  word_t            wdata,
   output word_t            rdata
);
   word_t mem_q [MEM_WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_WORDS; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[idx] <= wdata;
      end
   end

   assign rdata = mem_q[idx];
endmodule

// File: rtl/serdes_cr_port.sv
module serdes_cr_port
   import serdes_cr_pkg::*;
#(
   parameter logic [15:0] BASE_ADDR = 16'h80a0,
   parameter int unsigned LATENCY   = 4,
   parameter int unsigned MEM_WORDS = 64
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_wr,
   input  logic [15:0] host_addr,
   input  logic [15:0] host_wdata,
   output logic [15:0] host_rdata
);
   localparam int unsigned IDX_W = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;

   generate
      if (LATENCY < 1) begin : g_bad_latency
         $error("serdes_cr_port: LATENCY must be at least 1");
      end
      if ((MEM_WORDS < 2) || (MEM_WORDS > 32768) || ((1 << IDX_W) != MEM_WORDS)) begin : g_bad_depth
         $error("serdes_cr_port: MEM_WORDS must be a power of two between 2 and 32768");
      end
      if (BASE_ADDR > 16'hfffd) begin : g_bad_base
         $error("serdes_cr_port: BASE_ADDR leaves no room for three registers");
      end
   endgenerate

   sel_e             sel;
   logic             accept, dir_q, busy, done, rd_done, mem_we;
   word_t            addr_q, data_q, rd_word, mem_wdata;
   logic [IDX_W-1:0] mem_idx;
   cmd_t             cmd_in;

   assign cmd_in = '{is_write: host_wdata[DIR_BIT], addr: addr_q, data: data_q};

   serdes_cr_decode #(.BASE_ADDR(BASE_ADDR)) u_decode (
      .host_addr (host_addr),
      .sel       (sel)
   );

   serdes_cr_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .sel        (sel),
      .host_wdata (host_wdata),
      .busy       (busy),
      .rd_done    (rd_done),
      .rd_word    (rd_word),
      .accept     (accept),
      .dir_q      (dir_q),
      .addr_q     (addr_q),
      .data_q     (data_q),
      .host_rdata (host_rdata)
   );

   serdes_cr_engine #(.LATENCY(LATENCY), .IDX_W(IDX_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .cmd_in    (cmd_in),
      .busy      (busy),
      .done      (done),
      .rd_done   (rd_done),
      .mem_we    (mem_we),
      .mem_idx   (mem_idx),
      .mem_wdata (mem_wdata)
   );

   serdes_cr_mem #(.MEM_WORDS(MEM_WORDS), .IDX_W(IDX_W)) u_mem (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mem_we),
      .idx   (mem_idx),
      .wdata (mem_wdata),
      .rdata (rd_word)
   );
endmodule

// File: rtl/serdes_cr_port_chk.sv
module serdes_cr_port_chk #(
   parameter logic [15:0] BASE_ADDR = 16'h80a0
)(
   input logic        clk,
   input logic        rst_n,
   input logic        host_wr,
   input logic [15:0] host_addr,
   input logic [15:0] host_wdata,
   input logic        busy,
   input logic        done,
   input logic [15:0] addr_q,
   input logic [15:0] data_q
);
   logic start_idle, nostart_idle;

   assign start_idle   = host_wr && (host_addr == BASE_ADDR) && host_wdata[0] && !busy;
   assign nostart_idle = host_wr && (host_addr == BASE_ADDR) && !host_wdata[0] && !busy;

   a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_idle |=> busy);

   a_r3_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   a_r3_done_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   a_r8_busy_held_until_done: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   a_r7_no_start_without_bit: assert property (@(posedge clk) disable iff (!rst_n)
      nostart_idle |=> !busy);

   a_r9_addr_locked: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(addr_q));

   a_r9_data_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(data_q));
endmodule

bind serdes_cr_port serdes_cr_port_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .busy       (busy),
   .done       (done),
   .addr_q     (addr_q),
   .data_q     (data_q)
);

// File: tb/tb_serdes_cr_port.sv
`timescale 1ns/1ps
module tb_serdes_cr_port;
   localparam logic [15:0] CMD = 16'h80a0;
   localparam logic [15:0] ADR = 16'h80a1;
   localparam logic [15:0] DAT = 16'h80a2;
   localparam int LAT = 4;
   localparam int NVEC = 6;
   // {address, write data, expected readback}
   localparam logic [47:0] VEC [NVEC] = '{
      {16'h0000, 16'hA5A5, 16'hA5A5},
      {16'h003F, 16'h5A5A, 16'h5A5A},
      {16'h0012, 16'hFFFF, 16'hFFFF},
      {16'h1234, 16'h0001, 16'h0001},
      {16'h0007, 16'h8000, 16'h1357},
      {16'h0047, 16'h1357, 16'h1357}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [15:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   serdes_cr_port #(.BASE_ADDR(16'h80a0), .LATENCY(LAT), .MEM_WORDS(64)) dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
      end
   endtask

   task automatic cpu_write(input logic [15:0] a, input logic [15:0] d);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic cpu_read(input logic [15:0] a, output logic [15:0] d);
      host_addr = a;
      #1;
      d = host_rdata;
   endtask

   task automatic wait_idle(output int n);
      logic [15:0] c;
      n = 0;
      for (int i = 0; i < 64; i++) begin
         cpu_read(CMD, c);
         if (!c[0]) break;
         n++;
         @(negedge clk);
      end
   endtask

   task automatic run_cmd(input bit wr, input logic [15:0] a, input logic [15:0] d,
                          output logic [15:0] rd);
      int n;
      wait_idle(n);
      @(negedge clk);
      cpu_write(ADR, a);
      if (wr) cpu_write(DAT, d);
      cpu_write(CMD, wr ? 16'h0003 : 16'h0001);
      wait_idle(n);
      cpu_read(DAT, rd);
   endtask

   task automatic summary;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] v, v2;
      int n;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      cpu_read(CMD, v); check("R1 cmd reset", v, 16'h0000);
      cpu_read(ADR, v); check("R1 addr reset", v, 16'h0000);
      cpu_read(DAT, v); check("R1 data reset", v, 16'h0000);

      // R2 decode: stage values, poke unmapped addresses, read back
      @(negedge clk);
      cpu_write(ADR, 16'h0011);
      cpu_write(DAT, 16'h2222);
      cpu_write(16'h80a3, 16'hDEAD);
      cpu_write(16'h809f, 16'hBEEF);
      cpu_read(16'h80a3, v); check("R2 unmapped read", v, 16'h0000);
      cpu_read(ADR, v); check("R2 addr kept", v, 16'h0011);
      cpu_read(DAT, v); check("R2 data kept", v, 16'h2222);

      // R3 busy duration and R4 direction readback (write)
      @(negedge clk);
      cpu_write(CMD, 16'h0003);
      wait_idle(n);
      check("R3 busy cycles", 16'(n), 16'(LAT));
      cpu_read(CMD, v); check("R4 dir write readback", v, 16'h0002);

      // R5/R6 table walk: writes, then reads
      for (int i = 0; i < NVEC; i++)
         run_cmd(1'b1, VEC[i][47:32], VEC[i][31:16], v);
      for (int i = 0; i < NVEC; i++) begin
         run_cmd(1'b0, VEC[i][47:32], 16'h0000, v);
         check($sformatf("R5 R6 vector %0d", i), v, VEC[i][15:0]);
      end
      cpu_read(CMD, v); check("R4 dir read readback", v, 16'h0000);

      // R6 earlier staging write landed in word 0x11
      run_cmd(1'b0, 16'h0011, 16'h0000, v);
      check("R6 read staged word", v, 16'h2222);

      // R7 control write without start bit
      @(negedge clk);
      cpu_write(CMD, 16'h0002);
      cpu_read(CMD, v); check("R7 no start", v, 16'h0000);

      // R8 start while busy ignored
      run_cmd(1'b1, 16'h0020, 16'h4444, v);
      @(negedge clk);
      cpu_write(ADR, 16'h0021);
      cpu_write(DAT, 16'h6666);
      cpu_write(CMD, 16'h0003);
      cpu_write(CMD, 16'h0001);
      wait_idle(n);
      check("R8 remaining busy", 16'(n), 16'(LAT - 1));
      cpu_read(CMD, v); check("R8 dir kept", v, 16'h0002);
      cpu_read(DAT, v); check("R8 no extra read", v, 16'h6666);

      // R9 address/data writes during busy ignored
      @(negedge clk);
      cpu_write(ADR, 16'h0020);
      cpu_write(CMD, 16'h0001);
      cpu_write(ADR, 16'h0000);
      cpu_write(DAT, 16'h9999);
      wait_idle(n);
      cpu_read(ADR, v);  check("R9 addr locked", v, 16'h0020);
      cpu_read(DAT, v2); check("R9 read uses captured addr", v2, 16'h4444);

      finished = 1;
      summary();
      $finish;
   end
endmodule